// File: doc/BRIEF.md
# Non-Uniform Erase Range Walker

This block turns one erase request into a series of single-block erase commands for a flash array whose erase map has two regions. The lower region uses small blocks and the upper region uses large blocks. A request gives a byte start address and a byte length. The walker first checks that the request lies inside the device. It then checks that the start and the end each sit on a block boundary of the region they fall in.

For a legal request, the walker sends block addresses in ascending order to a downstream command sequencer. It waits for that sequencer to report done or fail on each block before it sends the next address. The step grows from the small block size to the large block size once the walk enters the upper region. Every request ends with a one-cycle status pulse that reports done, invalid or fail.

The state machine has five states:
- IDLE accepts a request.
- CHECK evaluates the captured request.
- ISSUE presents a block address.
- WAIT waits for the sequencer's answer.
- REPORT emits the status pulse.

The transitions are:
- IDLE→CHECK when a request is accepted.
- CHECK→REPORT for a zero length or an illegal request.
- CHECK→ISSUE for a legal request.
- ISSUE→WAIT on `cmd_ready`.
- WAIT→ISSUE on `blk_done` when blocks remain.
- WAIT→REPORT on `blk_done` for the last block, or on `blk_fail`.
- REPORT→IDLE always.

Top module: `erase_walker`

## Requirements
- R1: With default parameters the map is fixed. Region 0 covers bytes 0 to 131071 as 8 blocks of 16384 bytes. Region 1 starts at 131072 and holds 31 blocks of 131072 bytes. Capacity is 4194304 bytes. Every command address is a block base inside this map.
- R2: If start plus length, computed without wraparound, exceeds the capacity, the request ends with status code 2'b10 (invalid) and no command is issued. An end exactly equal to the capacity is legal.
- R3: A start address that is not a multiple of the block size of its region gives status 2'b10 and issues no command. An address below 131072 lies in region 0; any other address lies in region 1.
- R4: An end address (start plus length) that is not a multiple of the block size of its region gives status 2'b10 and issues no command. The region is chosen by the same rule as in R3, so an end of exactly 131072 counts as region 1.
- R5: A legal request issues exactly one command per block. The first command carries the start address. `cmd_valid` stays high with a stable `cmd_addr` until `cmd_ready` is seen.
- R6: Command addresses ascend. Each step is 16384 while the address is below 131072 and 131072 from then on. After the block that ends at the end address reports done, the status is 2'b01 (done).
- R7: A request with length zero ends with status 2'b01 and issues no command, whatever its start address.
- R8: A `blk_fail` during a walk ends the walk with status 2'b11 (fail), and no further command is issued.
- R9: `req_ready` is high only in IDLE. `busy` is high from the cycle after acceptance through the status pulse. A request presented while busy is ignored.
- R10: `sts_valid` is a pulse exactly one cycle long.
- R11: After a command is accepted, the next command is not presented until `blk_done` has answered the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Erase request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle if valid |
| req_start | input | AW | Byte start address |
| req_len | input | AW | Byte length |
| busy | output | 1 | Request in progress |
| cmd_valid | output | 1 | Block erase command present |
| cmd_ready | input | 1 | Sequencer takes the command |
| cmd_addr | output | AW | Base address of the block to erase |
| blk_done | input | 1 | Current block erased successfully |
| blk_fail | input | 1 | Current block erase failed |
| sts_valid | output | 1 | One-cycle status pulse |
| sts_code | output | 2 | 01 done, 10 invalid, 11 fail |

## Verification
The assertions check several rules on every cycle:
- every command address is a region-aligned block base below the capacity;
- addresses ascend within a walk;
- a stalled command holds its address;
- `busy` excludes `req_ready`;
- the status pulse lasts one cycle;
- a block failure is followed by a fail status.

Only the directed scenarios can show the rest. They show the exact address sequence across the region boundary and the rejection of each kind of illegal request with no command issued. They also cover the zero-length shortcut and the early stop after a failure. Finally, they confirm that requests presented during a walk leave it untouched.

// File: rtl/ew_pkg.sv
package ew_pkg;

    typedef enum logic [1:0] {
        STS_NONE    = 2'b00,
        STS_DONE    = 2'b01,
        STS_INVALID = 2'b10,
        STS_FAIL    = 2'b11
    } ew_status_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_ISSUE,
        S_WAIT,
        S_REPORT
    } ew_state_e;

endpackage

// File: rtl/ew_region_lookup.sv
module ew_region_lookup #(
    parameter int EW = 33,
    parameter int R0_SH = 14,
    parameter int R1_SH = 17,
    parameter logic [EW-1:0] R1_BASE = EW'(131072)
) (
    input  logic [EW-1:0] addr,
    output logic          in_r1,
    output logic          aligned
);

    always_comb begin
        in_r1 = (addr >= R1_BASE);
        if (in_r1) aligned = (addr[R1_SH-1:0] == '0);
        else       aligned = (addr[R0_SH-1:0] == '0);
    end

endmodule

// File: rtl/ew_req_check.sv
module ew_req_check #(
    parameter int AW = 32,
    parameter int EW = AW + 1,
    parameter int R0_SH = 14,
    parameter int R1_SH = 17,
    parameter logic [EW-1:0] R1_BASE = EW'(131072),
    parameter logic [EW-1:0] CAPACITY = EW'(4194304)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] start,
    input  logic [AW-1:0] len,
    output logic          zero,
    output logic          legal,
    output logic [EW-1:0] end_addr
);

    logic [EW-1:0] probe [2];
    logic [1:0]    in_r1;
    logic [1:0]    aligned;

    assign end_addr = {1'b0, start} + {1'b0, len};
    assign probe[0] = {1'b0, start};
    assign probe[1] = end_addr;

    for (genvar g = 0; g < 2; g++) begin : g_probe
        ew_region_lookup #(
            .EW(EW), .R0_SH(R0_SH), .R1_SH(R1_SH), .R1_BASE(R1_BASE)
        ) u_lookup (
            .addr   (probe[g]),
            .in_r1  (in_r1[g]),
            .aligned(aligned[g])
        );
    end

    assign zero  = (len == '0);
    assign legal = (end_addr <= CAPACITY) && aligned[0] && aligned[1];

    // R4: a legal nonzero range never ends in a lower region than it starts
    assert_end_region_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (legal && !zero) |-> (in_r1[1] || !in_r1[0]));

endmodule

// File: rtl/erase_walker.sv
module erase_walker
    import ew_pkg::*;
#(
    parameter int AW = 32,
    parameter int R0_SH = 14,
    parameter int R0_BLOCKS = 8,
    parameter int R1_SH = 17,
    parameter int R1_BLOCKS = 31
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_start,
    input  logic [AW-1:0] req_len,
    output logic          busy,
    output logic          cmd_valid,
    input  logic          cmd_ready,
    output logic [AW-1:0] cmd_addr,
    input  logic          blk_done,
    input  logic          blk_fail,
    output logic          sts_valid,
    output logic [1:0]    sts_code
);

    localparam int EW = AW + 1;
    localparam logic [EW-1:0] R0_STEP  = EW'(1) << R0_SH;
    localparam logic [EW-1:0] R1_STEP  = EW'(1) << R1_SH;
    localparam logic [EW-1:0] R1_BASE  = EW'(R0_BLOCKS) << R0_SH;
    localparam logic [EW-1:0] CAPACITY = R1_BASE + (EW'(R1_BLOCKS) << R1_SH);

    ew_state_e     state;
    ew_status_e    sts_q;
    logic [AW-1:0] start_q;
    logic [AW-1:0] len_q;
    logic [EW-1:0] cur_addr;
    logic [EW-1:0] end_q;
    logic [EW-1:0] next_addr;
    logic          chk_zero;
    logic          chk_legal;
    logic [EW-1:0] chk_end;
    logic          cur_in_r1;
    logic          cur_aligned;

    ew_req_check #(
        .AW(AW), .EW(EW), .R0_SH(R0_SH), .R1_SH(R1_SH),
        .R1_BASE(R1_BASE), .CAPACITY(CAPACITY)
    ) u_check (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_q),
        .len     (len_q),
        .zero    (chk_zero),
        .legal   (chk_legal),
        .end_addr(chk_end)
    );

    ew_region_lookup #(
        .EW(EW), .R0_SH(R0_SH), .R1_SH(R1_SH), .R1_BASE(R1_BASE)
    ) u_cur_lookup (
        .addr   (cur_addr),
        .in_r1  (cur_in_r1),
        .aligned(cur_aligned)
    );

    assign next_addr = cur_addr + (cur_in_r1 ? R1_STEP : R0_STEP);

    // State register and walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            sts_q    <= STS_NONE;
            start_q  <= '0;
            len_q    <= '0;
            cur_addr <= '0;
            end_q    <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        start_q <= req_start;
                        len_q   <= req_len;
                        state   <= S_CHECK;
                    end
                end
                S_CHECK: begin
                    if (chk_zero) begin
                        sts_q <= STS_DONE;
                        state <= S_REPORT;
                    end else if (!chk_legal) begin
                        sts_q <= STS_INVALID;
                        state <= S_REPORT;
                    end else begin
                        cur_addr <= {1'b0, start_q};
                        end_q    <= chk_end;
                        state    <= S_ISSUE;
                    end
                end
                S_ISSUE: begin
                    if (cmd_ready) state <= S_WAIT;
                end
                S_WAIT: begin
                    if (blk_fail) begin
                        sts_q <= STS_FAIL;
                        state <= S_REPORT;
                    end else if (blk_done) begin
                        if (next_addr == end_q) begin
                            sts_q <= STS_DONE;
                            state <= S_REPORT;
                        end else begin
                            cur_addr <= next_addr;
                            state    <= S_ISSUE;
                        end
                    end
                end
                S_REPORT: begin
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        req_ready = 1'b0;
        busy      = 1'b1;
        cmd_valid = 1'b0;
        cmd_addr  = cur_addr[AW-1:0];
        sts_valid = 1'b0;
        sts_code  = STS_NONE;
        unique case (state)
            S_IDLE: begin
                req_ready = 1'b1;
                busy      = 1'b0;
            end
            S_CHECK: ;
            S_ISSUE:  cmd_valid = 1'b1;
            S_WAIT: ;
            S_REPORT: begin
                sts_valid = 1'b1;
                sts_code  = sts_q;
            end
            default: ;
        endcase
    end

    // Tracker of the last accepted command, for the ordering assertion
    logic          have_last;
    logic [AW-1:0] last_cmd;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_last <= 1'b0;
            last_cmd  <= '0;
        end else if (state == S_IDLE) begin
            have_last <= 1'b0;
        end else if (cmd_valid && cmd_ready) begin
            have_last <= 1'b1;
            last_cmd  <= cmd_addr;
        end
    end

    assert_cmd_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ({1'b0, cmd_addr} < CAPACITY));

    assert_cmd_block_base_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (({1'b0, cmd_addr} < R1_BASE) ? (cmd_addr[R0_SH-1:0] == '0)
                                                    : (cmd_addr[R1_SH-1:0] == '0)));

    assert_walk_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ISSUE) |-> cur_aligned);

    assert_cmd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr)));

    assert_ascending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && have_last) |-> (cmd_addr > last_cmd));

    assert_fail_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_WAIT) && blk_fail) |=> (sts_valid && sts_code == STS_FAIL));

    assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready);

    assert_sts_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sts_valid |=> !sts_valid);

endmodule

// File: tb/erase_walker_tb.sv
module erase_walker_tb;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_start = '0;
    logic [31:0] req_len = '0;
    logic        busy;
    logic        cmd_valid;
    logic        cmd_ready = 1'b1;
    logic [31:0] cmd_addr;
    logic        blk_done = 1'b0;
    logic        blk_fail = 1'b0;
    logic        sts_valid;
    logic [1:0]  sts_code;

    int n_checks = 0;
    int n_err = 0;
    logic [31:0] got [64];
    logic [31:0] exp_a [64];
    int n_got;
    int n_exp;
    logic [1:0] code;

    always #(PERIOD/2) clk = ~clk;

    erase_walker u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_start(req_start), .req_len(req_len),
        .busy(busy),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .blk_done(blk_done), .blk_fail(blk_fail),
        .sts_valid(sts_valid), .sts_code(sts_code)
    );

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    // Expected address list from the map rules
    task automatic model(input logic [31:0] st, input logic [31:0] ln);
        logic [32:0] a;
        logic [32:0] e;
        a = {1'b0, st};
        e = {1'b0, st} + {1'b0, ln};
        n_exp = 0;
        while (a < e && n_exp < 64) begin
            exp_a[n_exp] = a[31:0];
            n_exp++;
            a = a + ((a < 33'd131072) ? 33'd16384 : 33'd131072);
        end
    endtask

    // Drive one request, answer blocks (fail_at = index to fail, -1 none)
    task automatic run_req(input logic [31:0] st, input logic [31:0] ln,
                           input int fail_at, input logic poke_busy);
        int pend;
        logic busy_ok;
        logic order_ok;
        pend = 0;
        busy_ok = 1'b1;
        order_ok = 1'b1;
        n_got = 0;
        code = 2'b00;
        @(negedge clk);
        req_valid = 1'b1;
        req_start = st;
        req_len   = ln;
        @(negedge clk);
        if (poke_busy) begin
            req_start = 32'd4096;
            req_len   = 32'd0;
        end else begin
            req_valid = 1'b0;
        end
        for (int cyc = 0; cyc < 2000; cyc++) begin
            if (cyc > 0) @(negedge clk);
            blk_done = 1'b0;
            blk_fail = 1'b0;
            if (sts_valid) begin
                code = sts_code;
                req_valid = 1'b0;
                break;
            end
            if (!busy || req_ready) busy_ok = 1'b0;
            if (cmd_valid) begin
                if (pend > 0) order_ok = 1'b0;
                if (n_got < 64) got[n_got] = cmd_addr;
                n_got++;
                pend = 2;
            end else if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    if (n_got - 1 == fail_at) blk_fail = 1'b1;
                    else blk_done = 1'b1;
                end
            end
        end
        check(busy_ok, "R9 busy high and req_ready low during request", {31'b0, busy_ok}, 32'd1);
        check(order_ok, "R11 next command only after done", {31'b0, order_ok}, 32'd1);
        @(negedge clk);
        check(!sts_valid, "R10 status pulse one cycle", {31'b0, sts_valid}, 32'd0);
        check(req_ready && !busy, "R9 idle after status", {30'b0, req_ready, busy}, 32'd2);
    endtask

    task automatic expect_walk(input string tag, input logic [31:0] st, input logic [31:0] ln);
        model(st, ln);
        run_req(st, ln, -1, 1'b0);
        check(code == 2'b01, {tag, " done status"}, {30'b0, code}, 32'd1);
        check(n_got == n_exp, {tag, " command count"}, n_got, n_exp);
        for (int i = 0; i < n_exp && i < n_got; i++)
            check(got[i] == exp_a[i], {tag, " command address"}, got[i], exp_a[i]);
    endtask

    task automatic expect_invalid(input string tag, input logic [31:0] st, input logic [31:0] ln);
        run_req(st, ln, -1, 1'b0);
        check(code == 2'b10, {tag, " invalid status"}, {30'b0, code}, 32'd2);
        check(n_got == 0, {tag, " no command"}, n_got, 0);
    endtask

    task automatic t_reset;
        check(req_ready == 1'b1, "R9 reset req_ready", {31'b0, req_ready}, 1);
        check(busy == 1'b0, "R9 reset busy", {31'b0, busy}, 0);
        check(cmd_valid == 1'b0, "R5 reset cmd_valid", {31'b0, cmd_valid}, 0);
        check(sts_valid == 1'b0, "R10 reset sts_valid", {31'b0, sts_valid}, 0);
    endtask

    task automatic t_zero_len;
        run_req(32'd4096, 32'd0, -1, 1'b0);
        check(code == 2'b01, "R7 zero length done", {30'b0, code}, 1);
        check(n_got == 0, "R7 zero length no command", n_got, 0);
    endtask

    task automatic t_fail;
        run_req(32'd0, 32'd65536, 1, 1'b0);
        check(code == 2'b11, "R8 fail status", {30'b0, code}, 3);
        check(n_got == 2, "R8 no command after fail", n_got, 2);
        check(got[1] == 32'd16384, "R8 failing block address", got[1], 32'd16384);
    endtask

    task automatic t_busy_ignored;
        model(32'd131072, 32'd262144);
        run_req(32'd131072, 32'd262144, -1, 1'b1);
        check(code == 2'b01, "R9 walk done despite request while busy", {30'b0, code}, 1);
        check(n_got == n_exp, "R9 request while busy ignored, count", n_got, n_exp);
        @(negedge clk);
        check(!sts_valid && !busy, "R9 no extra request after walk", {30'b0, sts_valid, busy}, 0);
    endtask

    initial begin
        #(PERIOD * 150000);
        n_err++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        expect_walk("R5 single small block", 32'd0, 32'd16384);
        expect_walk("R6 crossing into large region", 32'd98304, 32'd163840);
        expect_walk("R6 large region only", 32'd393216, 32'd262144);
        expect_walk("R2 end equals capacity", 32'd4063232, 32'd131072);
        expect_walk("R1 whole device", 32'd0, 32'd4194304);
        expect_invalid("R3 misaligned start small region", 32'd4096, 32'd12288);
        expect_invalid("R3 misaligned start large region", 32'd147456, 32'd245760);
        expect_invalid("R4 end misaligned in large region", 32'd0, 32'd147456);
        expect_invalid("R2 past capacity", 32'd4063232, 32'd262144);
        expect_invalid("R2 wraparound", 32'hFFFE0000, 32'h00040000);
        t_zero_len();
        t_fail();
        t_busy_ignored();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule